// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One channel of a programmable interval timer. A down-counter of `CNT_W` bits (16 by default) advances on cycles where the count-clock enable is high. It drives a single output whose waveform depends on one of six operating modes: a terminal-count flag, a retriggerable one-shot, a rate generator, a square-wave generator, and strobes started either by a count load or by a gate edge. A gate input pauses counting in some modes and restarts it on a rising edge in others.

A register front end, outside this block, decodes its accesses into single-cycle requests: a mode write with a 3-bit code, a count load with a 16-bit value, and a latch request. The block shows the live count. On a latch request it also captures a snapshot of that count, so software can read a stable value while the counter keeps running. A loaded value of zero stands for the full span of 2^`CNT_W` counts. Byte sequencing and decimal counting are left to the front end.

Top module: `ivt_channel`

## Requirements
- R1: After reset the channel is in mode 3 with the reload value 0 and the count 0. The output is high and counting runs at once: the first enabled step takes the count from 0 to 0xFFFF.
- R2: A load request sets the count and the reload value to `load_val_i` on the next clock edge. A loaded 0 counts as 65536, so in mode 0 the output rises exactly 65536 steps after the load.
- R3: Mode 0 (code 0). A load drives the output low. The output goes high on the step at which the count reaches 0 and stays high until the next load or mode write. While the gate is low, counting is paused.
- R4: Mode 1 (code 1), a retriggerable one-shot. A load leaves the output high. A gate rising edge reloads the count and drives the output low, and it returns high on the step at which the count reaches 0. A new rising edge during the low phase reloads the count again and so stretches the pulse. The gate level does not pause counting.
- R5: Mode 2 (code 2, with code 6 as an alias), a rate generator. The output is low for exactly the one step where the count equals 1. The next step reloads the count and drives the output high, which gives a period of N steps. A low gate pauses counting, and a gate rising edge reloads the count with the output high.
- R6: Mode 3 (code 3, with code 7 as an alias), a square wave. The count steps down by 1 and reloads after reaching 1. The output is high while the count is above N/2 (integer division), which makes it high for (N+1)/2 steps and low for N/2 steps of each period. The gate pauses counting and restarts it as in mode 2.
- R7: Mode 4 (code 4). A load drives the output high and arms a strobe. The output goes low for the single step at which the count reaches 0, then high again, and it gives no further strobe until the next load. A low gate pauses counting.
- R8: Mode 5 (code 5). A load does not arm the strobe, so the count passing 0 leaves the output high. A gate rising edge reloads the count and arms a one-step low strobe at count 0. The gate level does not pause counting.
- R9: A mode write sets the output to the new mode's initial level on the next edge: low for mode 0, high for all other modes. Counting then halts, with the count unchanged, until the next load.
- R10: The count changes only on cycles where `cnt_en` is high, a load or a gate restart excepted.
- R11: A latch request copies the count held before the edge into `snap_o`. The snapshot stays unchanged until the next latch request.
- R12: In modes 0, 1, 4 and 5 the count keeps stepping down past 0 and wraps to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable; one count step per cycle when high |
| load_i | input | 1 | Load request for `load_val_i` |
| load_val_i | input | CNT_W | Count value to load (0 means full span) |
| mode_wr_i | input | 1 | Mode write request; takes priority over a load in the same cycle |
| mode_i | input | 3 | Mode code for a mode write |
| gate_i | input | 1 | Gate level, synchronous to `clk` |
| latch_i | input | 1 | Snapshot request |
| out_o | output | 1 | Channel output (registered) |
| count_o | output | CNT_W | Live count (registered) |
| snap_o | output | CNT_W | Snapshot of the count at the last latch request |

## Verification
Assertions check on every cycle that the count holds without an event and steps down by exactly one on a non-periodic step. They also check that a load lands in both the count and the reload value, that a mode write produces the right initial level, and that the mode-0 flag stays high once set. Further cycle checks cover the mode 4/5 strobe, which lasts one step, the mode-2 low phase, which occurs only at count 1, and the snapshot, which holds the prior count. Only the bench scenarios can show whole-waveform properties: the rate period, the uneven high/low split for odd square-wave counts, the 65536-step span of a zero load, one-shot stretching by retrigger, gate pausing and restarting, and the mode aliases.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } ivt_mode_e;

  // Codes 6 and 7 fold onto the rate and square modes.
  function automatic ivt_mode_e fold_mode(input logic [2:0] raw);
    case (raw)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return ivt_mode_e'(raw);
    endcase
  endfunction

  function automatic logic idle_level(input ivt_mode_e m);
    return (m != M_TERM);
  endfunction

  function automatic logic gate_restarts(input ivt_mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTROBE);
  endfunction

  function automatic logic gate_pauses(input ivt_mode_e m);
    return (m == M_TERM) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTROBE);
  endfunction

  function automatic logic is_periodic(input ivt_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/ivt_gate_edge.sv
`timescale 1ns/1ps
module ivt_gate_edge #(
  parameter logic GATE_RST = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= GATE_RST;
    else     gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/ivt_count_core.sv
`timescale 1ns/1ps
module ivt_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_ev,
  input  logic         restart_ev,
  input  logic         step_ev,
  input  logic         periodic,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nx,
  output logic [W-1:0] reload_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    cnt_nx = cnt_q;
    if (load_ev)         cnt_nx = load_val;
    else if (restart_ev) cnt_nx = reload_q;
    else if (step_ev)    cnt_nx = (periodic && cnt_q == ONE) ? reload_q : cnt_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      if (load_ev) reload_q <= load_val;
    end
  end

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_ev || restart_ev || step_ev) |=> $stable(cnt_q));

  // R12
  cnt_wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ev && !periodic && !load_ev && !restart_ev) |=> (cnt_q == $past(cnt_q) - ONE));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> (cnt_q == $past(load_val) && reload_q == $past(load_val)));
endmodule

// File: rtl/ivt_out_gen.sv
`timescale 1ns/1ps
module ivt_out_gen import ivt_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_wr,
  input  ivt_mode_e    mode_new,
  input  ivt_mode_e    mode_q,
  input  logic         load_ev,
  input  logic         restart_ev,
  input  logic         step_ev,
  input  logic [W-1:0] cnt_nx,
  input  logic [W-1:0] reload_q,
  output logic         out_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W:0] span(input logic [W-1:0] x);
    return {(x == '0), x};
  endfunction

  logic         armed_q, armed_nx, out_nx;
  logic         hit_zero;
  logic [W:0]   half;

  assign hit_zero = (cnt_nx == '0);
  assign half     = span(reload_q) >> 1;

  always_comb begin
    out_nx   = out_q;
    armed_nx = armed_q;
    if (mode_wr) begin
      out_nx   = idle_level(mode_new);
      armed_nx = 1'b0;
    end else if (load_ev) begin
      out_nx   = (mode_q != M_TERM);
      armed_nx = (mode_q == M_SWSTROBE);
    end else if (restart_ev) begin
      out_nx   = (mode_q != M_ONESHOT);
      armed_nx = (mode_q == M_ONESHOT) || (mode_q == M_HWSTROBE);
    end else if (step_ev) begin
      case (mode_q)
        M_TERM:    out_nx = out_q | hit_zero;
        M_ONESHOT: out_nx = out_q | (armed_q & hit_zero);
        M_RATE:    out_nx = (cnt_nx != ONE);
        M_SQUARE:  out_nx = (span(cnt_nx) > half);
        default:   out_nx = ~(armed_q & hit_zero);
      endcase
      if (hit_zero) armed_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      out_q   <= out_nx;
      armed_q <= armed_nx;
    end
  end

  // R3
  term_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_TERM && out_q && !mode_wr && !load_ev) |=> out_q);

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == M_SWSTROBE || mode_q == M_HWSTROBE) && !out_q && step_ev) |=> out_q);
endmodule

// File: rtl/ivt_channel.sv
`timescale 1ns/1ps
module ivt_channel import ivt_pkg::*; #(
  parameter int   CNT_W    = 16,
  parameter logic GATE_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             mode_wr_i,
  input  logic [2:0]       mode_i,
  input  logic             gate_i,
  input  logic             latch_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] snap_o
);
  ivt_mode_e        mode_q, mode_new;
  logic             live_q;
  logic             gate_rise;
  logic             load_ev, restart_ev, step_ev;
  logic [CNT_W-1:0] cnt_nx, reload_q;

  assign mode_new   = fold_mode(mode_i);
  assign load_ev    = load_i & ~mode_wr_i;
  assign restart_ev = gate_rise & live_q & gate_restarts(mode_q) & ~mode_wr_i & ~load_i;
  assign step_ev    = cnt_en & live_q & (gate_i | ~gate_pauses(mode_q))
                      & ~mode_wr_i & ~load_i & ~restart_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_SQUARE;
      live_q <= 1'b1;
      snap_o <= '0;
    end else begin
      if (mode_wr_i) begin
        mode_q <= mode_new;
        live_q <= 1'b0;
      end else if (load_i) begin
        live_q <= 1'b1;
      end
      if (latch_i) snap_o <= count_o;
    end
  end

  ivt_gate_edge #(.GATE_RST(GATE_RST)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .gate_i (gate_i),
    .rise_o (gate_rise)
  );

  ivt_count_core #(.W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .load_ev    (load_ev),
    .restart_ev (restart_ev),
    .step_ev    (step_ev),
    .periodic   (is_periodic(mode_q)),
    .load_val   (load_val_i),
    .cnt_q      (count_o),
    .cnt_nx     (cnt_nx),
    .reload_q   (reload_q)
  );

  ivt_out_gen #(.W(CNT_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .mode_wr    (mode_wr_i),
    .mode_new   (mode_new),
    .mode_q     (mode_q),
    .load_ev    (load_ev),
    .restart_ev (restart_ev),
    .step_ev    (step_ev),
    .cnt_nx     (cnt_nx),
    .reload_q   (reload_q),
    .out_q      (out_o)
  );

  // R9
  mode_level_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr_i |=> (out_o == ($past(mode_i) != 3'd0)));

  // R9
  mode_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr_i && !load_i) |=> $stable(count_o));

  // R11
  snap_take_chk: assert property (@(posedge clk) disable iff (rst)
    latch_i |=> (snap_o == $past(count_o)));

  // R5
  rate_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RATE && !out_o) |-> (count_o == {{(CNT_W-1){1'b0}}, 1'b1}));

  // R10
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !load_i && !restart_ev) |=> $stable(count_o));
endmodule

// File: tb/ivt_channel_test.sv
`timescale 1ns/1ps
module ivt_channel_test;
  localparam int K_OUT = 0, K_CNT = 1, K_SNAP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b1, load_i = 1'b0, mode_wr_i = 1'b0, gate_i = 1'b1, latch_i = 1'b0;
  logic [15:0] load_val_i = '0;
  logic [2:0]  mode_i = '0;
  logic        out_o;
  logic [15:0] count_o, snap_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  typedef struct { int at; string tag; int kind; int val; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ivt_channel uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_i(load_i), .load_val_i(load_val_i),
    .mode_wr_i(mode_wr_i), .mode_i(mode_i), .gate_i(gate_i), .latch_i(latch_i),
    .out_o(out_o), .count_o(count_o), .snap_o(snap_o)
  );

  // Monitor: pops expectations due this cycle and compares.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at <= cyc) begin
        int act;
        act = (q[i].kind == K_OUT) ? int'(out_o) : (q[i].kind == K_CNT) ? int'(count_o) : int'(snap_o);
        checks++;
        if (q[i].at < cyc) begin
          failures++;
          $display("FAIL %s missed check at cycle %0d", q[i].tag, q[i].at);
        end else if (act != q[i].val) begin
          failures++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%0h expected=%0h", q[i].tag, q[i].kind, cyc, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic want(int d, string tag, int kind, int val);
    exp_t e;
    e.at = cyc + d; e.tag = tag; e.kind = kind; e.val = val;
    q.push_back(e);
  endtask

  task automatic do_mode(logic [2:0] m);
    mode_wr_i = 1'b1; mode_i = m; step(); mode_wr_i = 1'b0;
  endtask

  task automatic do_load(logic [15:0] v);
    load_i = 1'b1; load_val_i = v; step(); load_i = 1'b0;
  endtask

  initial begin
    steps(3);
    // R1 reset state
    want(1, "R1", K_OUT, 1); want(1, "R1", K_CNT, 0);
    step();
    rst = 1'b0;
    want(1, "R1", K_CNT, 16'hFFFF); want(1, "R1", K_OUT, 1); want(3, "R1", K_CNT, 16'hFFFD);
    steps(3);

    // R9 mode write: level and halt (count is 0xFFFD here)
    want(1, "R9", K_OUT, 0); want(1, "R9", K_CNT, 16'hFFFD); want(4, "R9", K_CNT, 16'hFFFD);
    do_mode(3'd0); steps(3);

    // R3 mode 0 terminal flag, R12 wrap
    want(1, "R3", K_CNT, 5); want(1, "R3", K_OUT, 0); want(5, "R3", K_CNT, 1); want(5, "R3", K_OUT, 0);
    want(6, "R3", K_CNT, 0); want(6, "R3", K_OUT, 1); want(7, "R12", K_CNT, 16'hFFFF); want(9, "R3", K_OUT, 1);
    do_load(16'd5); steps(9);

    // R3 gate low pauses mode 0
    want(1, "R3", K_CNT, 6);
    do_load(16'd6); step();
    gate_i = 1'b0;
    want(1, "R3", K_CNT, 5); want(3, "R3", K_CNT, 5); want(3, "R3", K_OUT, 0);
    steps(3);
    gate_i = 1'b1;
    want(1, "R3", K_CNT, 4);
    steps(2);

    // R10 enable low holds count (count is 3)
    cnt_en = 1'b0;
    want(1, "R10", K_CNT, 3); want(3, "R10", K_CNT, 3);
    steps(3);
    cnt_en = 1'b1;
    want(1, "R10", K_CNT, 2);
    steps(2);

    // R11 snapshot (count is 1)
    latch_i = 1'b1;
    want(1, "R11", K_SNAP, 1); want(4, "R11", K_SNAP, 1); want(4, "R12", K_CNT, 16'hFFFD);
    step(); latch_i = 1'b0; steps(4);

    // R2 zero load spans 65536 steps
    want(1, "R2", K_CNT, 0); want(65536, "R2", K_OUT, 0); want(65537, "R2", K_OUT, 1);
    do_load(16'd0); steps(65540);

    // R4 one-shot
    want(1, "R9", K_OUT, 1);
    do_mode(3'd1);
    want(1, "R4", K_OUT, 1); want(1, "R4", K_CNT, 3); want(5, "R4", K_OUT, 1);
    do_load(16'd3); steps(6);
    want(2, "R4", K_CNT, 3); want(2, "R4", K_OUT, 0); want(4, "R4", K_OUT, 0);
    want(5, "R4", K_OUT, 1); want(5, "R4", K_CNT, 0); want(6, "R12", K_CNT, 16'hFFFF);
    gate_i = 1'b0; step(); gate_i = 1'b1; steps(7);
    want(2, "R4", K_OUT, 0); want(3, "R4", K_CNT, 2); want(5, "R4", K_CNT, 3);
    want(7, "R4", K_OUT, 0); want(8, "R4", K_OUT, 1);
    gate_i = 1'b0; step(); gate_i = 1'b1; steps(2);
    gate_i = 1'b0; step(); gate_i = 1'b1; steps(6);

    // R5 rate generator via alias code 6
    want(1, "R5", K_OUT, 1);
    do_mode(3'd6);
    want(1, "R5", K_CNT, 4); want(1, "R5", K_OUT, 1); want(3, "R5", K_OUT, 1);
    want(4, "R5", K_CNT, 1); want(4, "R5", K_OUT, 0); want(5, "R5", K_CNT, 4);
    want(5, "R5", K_OUT, 1); want(8, "R5", K_OUT, 0); want(9, "R5", K_OUT, 1);
    do_load(16'd4); steps(9);
    gate_i = 1'b0;
    want(1, "R5", K_CNT, 3); want(2, "R5", K_CNT, 3);
    steps(2);
    gate_i = 1'b1;
    want(1, "R5", K_CNT, 4); want(1, "R5", K_OUT, 1); want(2, "R5", K_CNT, 3);
    steps(3);

    // R6 square wave, odd count via alias code 7
    do_mode(3'd7);
    want(1, "R6", K_OUT, 1); want(3, "R6", K_OUT, 1); want(4, "R6", K_OUT, 0);
    want(5, "R6", K_OUT, 0); want(5, "R6", K_CNT, 1); want(6, "R6", K_OUT, 1); want(6, "R6", K_CNT, 5);
    do_load(16'd5); steps(6);
    // R6 even count
    want(1, "R9", K_OUT, 1);
    do_mode(3'd3);
    want(2, "R6", K_OUT, 1); want(3, "R6", K_OUT, 0); want(4, "R6", K_OUT, 0); want(5, "R6", K_OUT, 1);
    do_load(16'd4); steps(5);

    // R7 software strobe
    do_mode(3'd4);
    want(1, "R7", K_CNT, 3); want(3, "R7", K_OUT, 1); want(4, "R7", K_OUT, 0); want(4, "R7", K_CNT, 0);
    want(5, "R7", K_OUT, 1); want(5, "R12", K_CNT, 16'hFFFF); want(8, "R7", K_OUT, 1);
    do_load(16'd3); steps(9);

    // R8 gate-started strobe
    do_mode(3'd5);
    want(1, "R8", K_CNT, 2); want(3, "R8", K_CNT, 0); want(3, "R8", K_OUT, 1);
    do_load(16'd2); steps(4);
    want(1, "R8", K_CNT, 16'hFFFD); want(2, "R8", K_CNT, 2); want(2, "R8", K_OUT, 1);
    want(3, "R8", K_CNT, 1); want(4, "R8", K_CNT, 0); want(4, "R8", K_OUT, 0);
    want(5, "R8", K_OUT, 1); want(8, "R8", K_OUT, 1);
    gate_i = 1'b0; step(); gate_i = 1'b1; steps(8);

    while (q.size() > 0) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired with %0d checks pending", q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule